// File: doc/BRIEF.md
# Two-Wire Quad Wiper Register Controller

This block is a slave on a two-wire serial bus. It owns four 8-bit wiper registers, which drive the wiper position outputs, and a bank of sixteen data registers. The data registers sit in four rows, and each row has one register per channel. SCL and SDA are sampled by the system clock. The block pulls SDA low through an open-drain output enable. It decodes a slave address byte, then an address byte that picks a channel or the status register, then data bytes. Byte writes, page writes of up to four bytes and sequential reads are supported. A random read is a write of the address byte followed by a repeated START and a read.

A volatile status register controls where data goes. It selects between the wiper registers and one row of data registers. Writing it with the data-register enable set copies the selected row into all four wipers. Data-register writes are staged and commit only at STOP, and only while the write-protect input is high. A commit also reloads every wiper from that row. It then starts a busy period of a fixed number of clock cycles, and during that period the slave does not acknowledge its address.

The control state machine has these states: S_IDLE, S_DEV (slave address bits), S_DEV_ACK, S_ADDR (address byte), S_ADDR_ACK, S_RX (write data), S_RX_ACK, S_TX (read data), S_TX_ACK (master acknowledge sample), S_TX_GO and S_WAIT (ignore the bus until START or STOP).

Its transitions:
- START from any state goes to S_DEV.
- STOP from any state goes to S_IDLE.
- S_DEV goes to S_DEV_ACK after eight bits if the address matches and the block is not busy; otherwise it goes to S_WAIT.
- S_DEV_ACK goes to S_TX for a read and to S_ADDR for a write.
- S_ADDR goes to S_ADDR_ACK, then to S_RX.
- S_RX goes to S_RX_ACK and back to S_RX.
- S_TX goes to S_TX_ACK. There a master ACK leads to S_TX_GO and then back to S_TX; a NACK leads to S_WAIT.

Top module: `qwiper_ctrl`

## Requirements
- R1: The slave address byte, MSB first, is type 0101, then three bits equal to dev_addr_i[2:0], then R/W (1 = read). Only a matching byte is acknowledged; any other byte gets no ACK and the rest of the transfer is ignored.
- R2: In a write, the slave ACKs the address byte and every following data byte. SDA is driven only in ACK slots and read-data bit slots.
- R3: Address byte 00h..03h selects channel 0..3 and 07h selects the status register. Bytes written to 04h..06h are acknowledged and change nothing. Reads from 04h..06h return 00h.
- R4: The status register resets to 00h. Bit 0 selects data registers (1) or wipers (0), bits 2:1 select the row, and bits 7:3 always read as 0. It is read back at address 07h.
- R5: With bit 0 clear, each written byte goes to the wiper at the channel pointer. The pointer then advances and wraps from 3 to 0, so bytes beyond four overwrite earlier ones.
- R6: A status write with bit 0 set copies all four data registers of the selected row into the wipers.
- R7: A read returns the byte at the pointer and then advances the pointer with wrap. It continues while the master ACKs and stops after a NACK. In data-register mode the byte comes from the selected row, and that channel's wiper loads it.
- R8: Data-register bytes commit at STOP if wp_i is high. The written registers take the new bytes, and every wiper reloads from the row. busy_o is then high for exactly BUSY_CYCLES clock cycles.
- R9: While busy_o is high, the slave address is not acknowledged.
- R10: If wp_i is low at STOP, the staged bytes are discarded, the data registers and wipers are unchanged, and busy_o stays low.
- R11: After reset every wiper and every row-0 data register holds ROW0_VAL, other rows hold 00h, the pointer is channel 0, and busy_o is low.
- R12: A repeated START abandons any partial byte and restarts slave address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock level |
| sda_i | input | 1 | Serial data level seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| dev_addr_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | 1 allows data-register commits |
| busy_o | output | 1 | High during the simulated write cycle |
| wiper_o | output | 32 | Four wiper codes, channel c at bits 8c+7:8c |

## Verification
Assertions watch four things on every cycle:
- SDA is driven only while the slave owns the bus.
- An acknowledged slave address always matches the type and strap bits, and busy is never high while acknowledging.
- A busy period begins only after a write-enabled commit.
- A write-protected commit leaves the wipers untouched.

Only the bench scenarios can show the rest: that the byte values land in the right wipers and data registers, the page wrap and overwrite order, row copies on status writes, the exact busy length, and the values returned by random reads across the wrap point.

// File: rtl/qw_pkg.sv
package qw_pkg;
    localparam int DW    = 8;
    localparam int NCH   = 4;
    localparam int NROW  = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int ROW_W = $clog2(NROW);
    localparam logic [3:0]    DEV_TYPE = 4'b0101;
    localparam logic [DW-1:0] SR_ADDR  = 8'h07;

    typedef enum logic [2:0] {
        RF_NOP, RF_WIPER, RF_ROWLOAD, RF_CHLOAD, RF_STAGE, RF_COMMIT, RF_CLEAR
    } rf_op_e;

    typedef enum logic [1:0] {TG_CH, TG_SR, TG_NONE} tgt_e;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK,
        S_TX, S_TX_ACK, S_TX_GO, S_WAIT
    } st_e;

    typedef struct packed {
        rf_op_e            op;
        logic [ROW_W-1:0]  row;
        logic [CH_W-1:0]   ch;
        logic [DW-1:0]     data;
    } rf_cmd_t;
endpackage

// File: rtl/qw_bus_sense.sv
module qw_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_lvl
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] scl_p, sda_p;
    logic scl_now, scl_prev, sda_now, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[TOP-1:0], scl_i};
            sda_p <= {sda_p[TOP-1:0], sda_i};
        end
    end

    assign scl_now  = scl_p[TOP-1];
    assign scl_prev = scl_p[TOP];
    assign sda_now  = sda_p[TOP-1];
    assign sda_prev = sda_p[TOP];

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign bus_start = scl_now & scl_prev & sda_prev & ~sda_now;
    assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
    assign sda_lvl   = sda_now;
endmodule

// File: rtl/qw_regfile.sv
module qw_regfile
    import qw_pkg::*;
#(
    parameter int          BUSY_CYCLES = 600,
    parameter logic [DW-1:0] ROW0_VAL  = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rf_cmd_t              cmd,
    input  logic                 wp_i,
    input  logic [ROW_W-1:0]     rd_row,
    input  logic [CH_W-1:0]      rd_ch,
    output logic [DW-1:0]        rd_dr,
    output logic [NCH*DW-1:0]    wiper_o,
    output logic                 busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [DW-1:0]   dr  [NROW][NCH];
    logic [DW-1:0]   wip [NCH];
    logic [DW-1:0]   stg [NCH];
    logic [NCH-1:0]  stg_v;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCH; c++)
                    dr[r][c] <= (r == 0) ? ROW0_VAL : '0;
            for (int c = 0; c < NCH; c++) begin
                wip[c] <= ROW0_VAL;
                stg[c] <= '0;
            end
            stg_v <= '0;
            cnt   <= '0;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            unique case (cmd.op)
                RF_WIPER:   wip[cmd.ch] <= cmd.data;
                RF_ROWLOAD: for (int c = 0; c < NCH; c++) wip[c] <= dr[cmd.row][c];
                RF_CHLOAD:  wip[cmd.ch] <= dr[cmd.row][cmd.ch];
                RF_STAGE: begin
                    stg[cmd.ch]   <= cmd.data;
                    stg_v[cmd.ch] <= 1'b1;
                end
                RF_CLEAR:   stg_v <= '0;
                RF_COMMIT: begin
                    if ((stg_v != '0) && wp_i && (cnt == '0)) begin
                        for (int c = 0; c < NCH; c++) begin
                            if (stg_v[c]) begin
                                dr[cmd.row][c] <= stg[c];
                                wip[c]         <= stg[c];
                            end else begin
                                wip[c]         <= dr[cmd.row][c];
                            end
                        end
                        cnt <= CNT_W'(BUSY_CYCLES);
                    end
                    stg_v <= '0;
                end
                default: ;
            endcase
        end
    end

    assign rd_dr  = dr[rd_row][rd_ch];
    assign busy_o = (cnt != '0);

    for (genvar g = 0; g < NCH; g++) begin : g_wout
        assign wiper_o[g*DW +: DW] = wip[g];
    end

    // R8: a busy period only follows a write-enabled commit
    a_r8_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cmd.op) == RF_COMMIT) && $past(wp_i));

    // R10: a write-protected commit touches no wiper and starts no busy period
    a_r10_wp_keeps_wipers: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.op == RF_COMMIT && !wp_i && !busy_o) |=> $stable(wiper_o) && !busy_o);
endmodule

// File: rtl/qwiper_ctrl.sv
module qwiper_ctrl
    import qw_pkg::*;
#(
    parameter int          BUSY_CYCLES = 600,
    parameter logic [7:0]  ROW0_VAL    = 8'h80,
    parameter int          SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_oe_o,
    input  logic [2:0]   dev_addr_i,
    input  logic         wp_i,
    output logic         busy_o,
    output logic [31:0]  wiper_o
);
    logic ev_rise, ev_fall, ev_start, ev_stop, sda_s;

    qw_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(ev_rise), .scl_fall(ev_fall),
        .bus_start(ev_start), .bus_stop(ev_stop), .sda_lvl(sda_s)
    );

    st_e              st, nxt;
    logic [3:0]       bitc;
    logic [DW-1:0]    sh;
    logic             rw_q, drive_q;
    tgt_e             tgt;
    logic [CH_W-1:0]  ptr;
    logic [2:0]       sr;
    rf_cmd_t          cmd_q;
    logic [DW-1:0]    rd_dr, rd_byte;
    logic             byte_done, dev_ok, tx_load;

    qw_regfile #(.BUSY_CYCLES(BUSY_CYCLES), .ROW0_VAL(ROW0_VAL)) u_rf (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .wp_i(wp_i),
        .rd_row(sr[2:1]), .rd_ch(ptr), .rd_dr(rd_dr),
        .wiper_o(wiper_o), .busy_o(busy_o)
    );

    assign byte_done = ev_fall && (bitc == 4'd8);
    assign dev_ok    = (sh[7:4] == DEV_TYPE) && (sh[3:1] == dev_addr_i) && !busy_o;
    assign tx_load   = ev_fall && ((st == S_DEV_ACK && rw_q) || st == S_TX_GO);

    always_comb begin
        unique case (tgt)
            TG_SR:   rd_byte = {5'b0, sr};
            TG_CH:   rd_byte = sr[0] ? rd_dr : wiper_o[ptr*DW +: DW];
            default: rd_byte = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (ev_start)     nxt = S_DEV;
        else if (ev_stop) nxt = S_IDLE;
        else begin
            unique case (st)
                S_IDLE:     nxt = S_IDLE;
                S_DEV:      if (byte_done) nxt = dev_ok ? S_DEV_ACK : S_WAIT;
                S_DEV_ACK:  if (ev_fall) nxt = rw_q ? S_TX : S_ADDR;
                S_ADDR:     if (byte_done) nxt = S_ADDR_ACK;
                S_ADDR_ACK: if (ev_fall) nxt = S_RX;
                S_RX:       if (byte_done) nxt = S_RX_ACK;
                S_RX_ACK:   if (ev_fall) nxt = S_RX;
                S_TX:       if (byte_done) nxt = S_TX_ACK;
                S_TX_ACK:   if (ev_rise) nxt = sda_s ? S_WAIT : S_TX_GO;
                S_TX_GO:    if (ev_fall) nxt = S_TX;
                S_WAIT:     nxt = S_WAIT;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitc    <= '0;
            sh      <= '0;
            rw_q    <= 1'b0;
            drive_q <= 1'b0;
            tgt     <= TG_CH;
            ptr     <= '0;
            sr      <= '0;
            cmd_q   <= '{op: RF_NOP, row: '0, ch: '0, data: '0};
        end else begin
            cmd_q <= '{op: RF_NOP, row: '0, ch: '0, data: '0};
            if (ev_start) begin
                bitc     <= '0;
                drive_q  <= 1'b0;
                cmd_q.op <= RF_CLEAR;
            end else if (ev_stop) begin
                drive_q <= 1'b0;
                cmd_q   <= '{op: RF_COMMIT, row: sr[2:1], ch: '0, data: '0};
            end else begin
                unique case (st)
                    S_DEV, S_ADDR, S_RX: begin
                        if (ev_rise) begin
                            sh   <= {sh[6:0], sda_s};
                            bitc <= bitc + 4'd1;
                        end else if (byte_done) begin
                            bitc <= '0;
                            if (st == S_DEV) begin
                                drive_q <= dev_ok;
                                if (dev_ok) rw_q <= sh[0];
                            end else if (st == S_ADDR) begin
                                drive_q <= 1'b1;
                                if (sh < DW'(NCH)) begin
                                    tgt <= TG_CH;
                                    ptr <= sh[CH_W-1:0];
                                end else if (sh == SR_ADDR) tgt <= TG_SR;
                                else                        tgt <= TG_NONE;
                            end else begin
                                drive_q <= 1'b1;
                                if (tgt == TG_SR) begin
                                    sr <= sh[2:0];
                                    if (sh[0]) cmd_q <= '{op: RF_ROWLOAD, row: sh[2:1], ch: '0, data: '0};
                                end else if (tgt == TG_CH) begin
                                    cmd_q <= '{op: sr[0] ? RF_STAGE : RF_WIPER, row: sr[2:1], ch: ptr, data: sh};
                                    ptr   <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    S_DEV_ACK, S_ADDR_ACK, S_RX_ACK: if (ev_fall) drive_q <= 1'b0;
                    S_TX: begin
                        if (ev_rise) bitc <= bitc + 4'd1;
                        else if (ev_fall) begin
                            if (bitc == 4'd8) drive_q <= 1'b0;
                            else begin
                                sh      <= {sh[6:0], 1'b0};
                                drive_q <= ~sh[6];
                            end
                        end
                    end
                    S_IDLE, S_TX_ACK, S_TX_GO, S_WAIT: ;
                    default: ;
                endcase
                if (tx_load) begin
                    sh      <= rd_byte;
                    bitc    <= '0;
                    drive_q <= ~rd_byte[7];
                    if (tgt == TG_CH) begin
                        ptr <= ptr + 1'b1;
                        if (sr[0]) cmd_q <= '{op: RF_CHLOAD, row: sr[2:1], ch: ptr, data: '0};
                    end
                end
            end
        end
    end

    assign sda_oe_o = drive_q;

    // R2: SDA is pulled only in ACK slots and read-data slots
    a_r2_oe_owned: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (st inside {S_DEV_ACK, S_ADDR_ACK, S_RX_ACK, S_TX}));

    // R1: an acknowledged slave address matches type and strap bits
    a_r1_ack_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DEV_ACK) |-> (sh[7:4] == 4'b0101) && (sh[3:1] == dev_addr_i));

    // R9: never acknowledging the address while busy
    a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DEV_ACK && sda_oe_o) |-> !busy_o);

    // R12: a START always sends the FSM back to address reception
    a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (st == S_DEV) && (bitc == 4'd0));
endmodule

// File: tb/qwiper_ctrl_tb_top.sv
module qwiper_ctrl_tb_top;
    localparam int Q    = 5;
    localparam int BUSY = 600;
    localparam logic [7:0] ROW0 = 8'h80;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl = 1'b1, sda_m = 1'b1, wp = 1'b1;
    logic [2:0] dev = 3'b101;
    wire  sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;
    wire  busy;
    wire [31:0] wiper;

    qwiper_ctrl #(.BUSY_CYCLES(BUSY), .ROW0_VAL(ROW0)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .dev_addr_i(dev), .wp_i(wp), .busy_o(busy), .wiper_o(wiper)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference model
    int m_dr[4][4];
    int m_wip[4];
    int m_sr, m_ptr, m_tgt;
    int stg[4];
    bit stg_v[4];
    int txq[$];

    bit mon_on = 0, mon_bad = 0;
    int run = 0, last_run = 0;

    always @(negedge clk) begin
        if (mon_on)
            for (int c = 0; c < 4; c++)
                if (wiper[c*8 +: 8] !== m_wip[c][7:0]) mon_bad = 1;
        if (busy) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic close_win(string tag);
        check(tag, mon_bad, 0);
        mon_bad = 0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
    endtask

    task automatic send_bit(bit b);
        sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1; tick(Q); scl = 1; tick(Q);
        ack = !sda_bus;
        tick(Q); scl = 0; tick(Q);
    endtask

    task automatic rd_byte(bit m_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; tick(Q); scl = 1; tick(Q);
            b[i] = sda_bus;
            tick(Q); scl = 0; tick(Q);
        end
        send_bit(!m_ack);
    endtask

    task automatic m_addr(int a);
        if (a < 4) begin m_tgt = 0; m_ptr = a; end
        else if (a == 7) m_tgt = 1;
        else m_tgt = 2;
    endtask

    task automatic m_data(int d);
        if (m_tgt == 1) begin
            m_sr = d & 7;
            if (d & 1) for (int c = 0; c < 4; c++) m_wip[c] = m_dr[(d >> 1) & 3][c];
        end else if (m_tgt == 0) begin
            if (m_sr & 1) begin stg[m_ptr] = d; stg_v[m_ptr] = 1; end
            else m_wip[m_ptr] = d;
            m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    task automatic m_stop();
        bit any = 0;
        int row = (m_sr >> 1) & 3;
        for (int c = 0; c < 4; c++) any |= stg_v[c];
        if (any && wp)
            for (int c = 0; c < 4; c++) begin
                if (stg_v[c]) m_dr[row][c] = stg[c];
                m_wip[c] = m_dr[row][c];
            end
        for (int c = 0; c < 4; c++) stg_v[c] = 0;
    endtask

    function automatic int m_read();
        int v;
        if (m_tgt == 1) v = m_sr;
        else if (m_tgt == 2) v = 0;
        else begin
            if (m_sr & 1) begin
                v = m_dr[(m_sr >> 1) & 3][m_ptr];
                m_wip[m_ptr] = v;
            end else v = m_wip[m_ptr];
            m_ptr = (m_ptr + 1) % 4;
        end
        return v;
    endfunction

    task automatic do_write(string tag, int addr);
        bit ack, all_ack;
        mon_on = 0;
        bstart();
        for (int c = 0; c < 4; c++) stg_v[c] = 0;
        wr_byte({4'b0101, dev, 1'b0}, ack); all_ack = ack;
        wr_byte(addr[7:0], ack); all_ack &= ack; m_addr(addr);
        foreach (txq[i]) begin
            wr_byte(txq[i][7:0], ack); all_ack &= ack; m_data(txq[i]);
        end
        bstop(); m_stop();
        tick(8);
        check({tag, " R2 write ACKs"}, all_ack, 1);
        mon_on = 1;
    endtask

    task automatic do_read(string tag, int addr, int n);
        bit ack, all_ack;
        logic [7:0] b;
        int exp;
        mon_on = 0;
        bstart();
        for (int c = 0; c < 4; c++) stg_v[c] = 0;
        wr_byte({4'b0101, dev, 1'b0}, ack); all_ack = ack;
        wr_byte(addr[7:0], ack); all_ack &= ack; m_addr(addr);
        bstart();  // R12 repeated START
        wr_byte({4'b0101, dev, 1'b1}, ack); all_ack &= ack;
        check({tag, " R12 random read ACKs"}, all_ack, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, b);
            exp = m_read();
            check({tag, " R7 read byte"}, b, exp);
        end
        bstop(); m_stop();
        tick(8);
        mon_on = 1;
    endtask

    initial begin
        bit ack;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) m_dr[r][c] = (r == 0) ? ROW0 : 0;
        for (int c = 0; c < 4; c++) begin m_wip[c] = ROW0; stg_v[c] = 0; end
        m_sr = 0; m_ptr = 0; m_tgt = 0;
        tick(10); rst_n = 1; tick(5);

        // R11 reset state
        for (int c = 0; c < 4; c++) check("R11 reset wiper", wiper[c*8 +: 8], ROW0);
        check("R11 reset busy", busy, 0);
        mon_on = 1;

        // R1 wrong type id and wrong strap bits are not acknowledged
        mon_on = 0;
        bstart(); wr_byte(8'b0110_1010, ack); bstop();
        check("R1 wrong type NACK", ack, 0);
        bstart(); wr_byte({4'b0101, 3'b000, 1'b0}, ack); bstop();
        check("R1 wrong strap NACK", ack, 0);
        tick(8); mon_on = 1;

        // R3/R5 byte write to channel 2
        txq = {32'h3C}; do_write("R3 byte", 2);
        check("R5 byte write ch2", wiper[23:16], 8'h3C);
        close_win("R5 window");

        // R5 page write with wrap and overwrite
        txq = {32'h10, 32'h20, 32'h30, 32'h40, 32'h50, 32'h60}; do_write("R5 page", 1);
        check("R5 wrap overwrite ch1", wiper[15:8], 8'h50);
        check("R5 wrap ch0", wiper[7:0], 8'h40);
        close_win("R5 page window");

        // R3 unused address written: nothing changes
        txq = {32'hEE}; do_write("R3 unused", 5);
        close_win("R3 unused write ignored");

        // R6 status write loads row 1 (all zero)
        txq = {32'h03}; do_write("R6 sr", 7);
        check("R6 row load ch3", wiper[31:24], 8'h00);
        close_win("R6 window");

        // R8 data-register page write with wp high
        txq = {32'hA1, 32'hB2, 32'hC3, 32'hD4}; do_write("R8 nv", 0);
        check("R8 busy after commit", busy, 1);
        check("R8 wiper ch3 committed", wiper[31:24], 8'hD4);
        // R9 no ACK while busy
        mon_on = 0;
        bstart(); wr_byte({4'b0101, dev, 1'b0}, ack); bstop();
        check("R9 address NACK while busy", ack, 0);
        tick(4); mon_on = 1;
        while (busy) tick(1);
        tick(2);
        check("R8 busy length", last_run, BUSY);
        close_win("R8 window");

        // R6 volatile change then row reload
        txq = {32'h02}; do_write("R6 vol", 7);
        txq = {32'h11, 32'h22, 32'h33, 32'h44}; do_write("R6 wip", 0);
        check("R5 volatile ch2", wiper[23:16], 8'h33);
        txq = {32'h03}; do_write("R6 reload", 7);
        check("R6 reload ch2", wiper[23:16], 8'hC3);
        close_win("R6 reload window");

        // R10 write protect discards
        wp = 0;
        txq = {32'h5A}; do_write("R10 wp", 2);
        tick(20);
        check("R10 no busy", busy, 0);
        check("R10 wiper ch2 kept", wiper[23:16], 8'hC3);
        close_win("R10 window");
        wp = 1;

        // R7 sequential read with wrap, R12 random read
        do_read("R7 seq", 1, 4);
        close_win("R7 window");
        // R4 status read back
        do_read("R4 status", 7, 1);
        // R3 unused read returns zero
        do_read("R3 unused read", 5, 1);
        close_win("R3 window");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule